// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block is the host-side engine that writes one page into a byte-wide NAND device. A caller pulses `start` with a row (page) address, a starting column, a byte count and two per-operation choices. The block then drives the multiplexed 8-bit bus and its strobes (chip select, command latch, address latch, write strobe, read strobe) through the whole program sequence. It pulls data bytes from the caller one at a time through a take pulse. When the device has finished, the block reads status and reports the outcome with a one-cycle `done` pulse and a sticky fail flag.

The page holds 512 main bytes plus 16 spare bytes. A column pointer command selects the region that the start column lies in. The transfer length is clamped so that it never runs past the end of the page. Completion is found either by waiting for the ready/busy line or by polling status. When the caller asks for it, and no error-correcting code protects the data, a read-back pass re-reads the page and compares it against the same byte stream, which the caller presents a second time. All bus timing is counted in clock cycles set by parameters.

Top module: `nand_pgm_seq`

## Requirements
- R1: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_io_oe` are 0, and `busy`, `done`, `prog_fail`, `verify_fail` and `din_take` are 0.
- R2: A program operation writes in this order: a pointer command (00h when the start column is below 256, 01h for 256 to 511, 50h for 512 and above), command 80h, the address bytes column[7:0], row[7:0] and row[15:8] (ALE high), the data bytes (CLE and ALE low), then command 10h (CLE high).
- R3: The number of data bytes is the smaller of `byte_count` and 528 minus the start column. A count of zero writes no data byte, and 10h follows the address directly.
- R4: Every bus cycle holds its strobe low for at least 25 ns within a cycle of at least 50 ns. Write and read strobes are never low together, and `nand_io_out`, `nand_cle` and `nand_ale` stay stable while the write strobe is low.
- R5: After 10h the ready/busy input is ignored for `T_WB` cycles. In ready/busy mode (`status_poll`=0), the status command 70h is written only once the line is high again.
- R6: In status mode (`status_poll`=1), 70h is written after the wait of R5, and status is read repeatedly until bit 6 is 1. In both modes at least 60 ns pass from the 70h write-strobe rising edge to the first read-strobe falling edge.
- R7: Final status bit 0 equal to 1 sets `prog_fail`, and the operation ends without a verify pass.
- R8: With `verify_en`=1, no program failure and a nonzero length, the block writes the pointer command and the three address bytes again, waits at least `T_RD` cycles and for ready, reads the same number of bytes, and sets `verify_fail` if any byte differs from `din`.
- R9: `done` is a single-cycle pulse. In that cycle `busy` is 0 and `nand_ce_n` is 1. `busy` is 1 from the cycle after an accepted start until then.
- R10: A `start` pulse while `busy` is 1 is ignored: no extra bus cycles follow and only one `done` pulse occurs.
- R11: `din_take` pulses once for each data byte written and once for each byte compared during the verify pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one page program operation |
| row_addr | input | 16 | Page (row) address |
| col_start | input | 10 | First column to write |
| byte_count | input | 10 | Requested byte count (clamped to the page end) |
| status_poll | input | 1 | 1: detect completion by status bit 6; 0: by ready/busy |
| verify_en | input | 1 | 1: run the read-back compare pass |
| din | input | 8 | Current byte of the caller's stream |
| din_take | output | 1 | Pulse: `din` consumed, present the next byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prog_fail | output | 1 | Status reported a program error |
| verify_fail | output | 1 | Read-back data mismatched |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |

## Verification
Operations are run with start columns in each of the three pointer regions, so that 00h, 01h and 50h are all seen. One request runs past the page end, to show the clamp, and one has a zero count, to show the skipped data phase. Ready/busy completion and status-poll completion are both exercised; the status-poll case proves that repeated reads are issued while bit 6 is low. A status reply with bit 0 set must end the operation without a verify pass, while a corrupted read-back byte must raise only the verify flag. A second start pulse in mid-operation must leave the bus sequence and the single done pulse unchanged.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_SETUP, S_ADR, S_DATA, S_CONF, S_WB, S_RBW,
    S_STCMD, S_WHR, S_STRD, S_RWAIT, S_RRBW, S_VRD, S_FIN
  } seq_st_t;

  typedef enum logic [1:0] {P_IDLE, P_LO, P_HI} strb_ph_t;

  localparam logic [7:0] CMD_AREA0  = 8'h00;
  localparam logic [7:0] CMD_AREA1  = 8'h01;
  localparam logic [7:0] CMD_SPARE  = 8'h50;
  localparam logic [7:0] CMD_LOAD   = 8'h80;
  localparam logic [7:0] CMD_COMMIT = 8'h10;
  localparam logic [7:0] CMD_STATUS = 8'h70;
endpackage

// File: rtl/nps_strobe.sv
module nps_strobe
  import nps_pkg::*;
#(
  parameter int DW   = 8,
  parameter int T_LO = 3,
  parameter int T_HI = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          rd,
  input  logic [DW-1:0] io_in,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] rdata,
  output logic          ack
);
  localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int CW   = $clog2(TMAX + 1);

  strb_ph_t      ph;
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= P_IDLE;
      cnt   <= '0;
      rd_q  <= 1'b0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      rdata <= '0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (ph)
        P_IDLE: if (go) begin
          ph   <= P_LO;
          cnt  <= CW'(T_LO - 1);
          rd_q <= rd;
          if (rd) re_n <= 1'b0;
          else    we_n <= 1'b0;
        end
        P_LO: if (cnt == '0) begin
          ph   <= P_HI;
          cnt  <= CW'(T_HI - 1);
          we_n <= 1'b1;
          re_n <= 1'b1;
          if (rd_q) rdata <= io_in;
        end else cnt <= cnt - 1'b1;
        P_HI: if (cnt == '0) begin
          ph  <= P_IDLE;
          ack <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= P_IDLE;
      endcase
    end
  end

  // R4
  strobes_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  // R4
  go_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> (ph == P_IDLE));
endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nps_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ROW_BYTES  = 2,
  parameter int MAIN_BYTES = 512,
  parameter int PAGE_BYTES = 528,
  parameter int COL_W      = 10,
  parameter int T_WB       = 10,
  parameter int T_WHR      = 6,
  parameter int T_RD       = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ROW_BYTES*DW-1:0] row_addr,
  input  logic [COL_W-1:0]        col_start,
  input  logic [COL_W-1:0]        byte_count,
  input  logic                    status_poll,
  input  logic                    verify_en,
  input  logic [DW-1:0]           din,
  output logic                    din_take,
  output logic                    busy,
  output logic                    done,
  output logic                    prog_fail,
  output logic                    verify_fail,
  output logic                    ce_n,
  output logic                    cle,
  output logic                    ale,
  output logic [DW-1:0]           io_out,
  output logic                    io_oe,
  output logic                    go,
  output logic                    rd,
  input  logic                    ack,
  input  logic [DW-1:0]           rdata,
  input  logic                    rb
);
  localparam int ROW_W  = ROW_BYTES * DW;
  localparam int HALF   = MAIN_BYTES / 2;
  localparam int AIW    = $clog2(ROW_BYTES + 1);
  localparam int RWAIT  = (T_RD > T_WB) ? T_RD : T_WB;
  localparam int WMAX   = (RWAIT > T_WHR) ? RWAIT : T_WHR;
  localparam int CW     = $clog2(WMAX + 1);

  seq_st_t          st;
  logic             issued, vph, spoll_q, vrf_q;
  logic [AIW-1:0]   aidx;
  logic [COL_W-1:0] col_q, len_q, left, room, req_len;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    wcnt;
  logic [1:0]       rb_s;
  logic [DW-1:0]    ptr_cmd;
  logic [DW-1:0]    abytes [0:ROW_BYTES];

  assign room    = (col_start >= COL_W'(PAGE_BYTES)) ? '0 : COL_W'(PAGE_BYTES) - col_start;
  assign req_len = (byte_count < room) ? byte_count : room;
  assign ptr_cmd = (col_q >= COL_W'(MAIN_BYTES)) ? CMD_SPARE :
                   (col_q >= COL_W'(HALF))       ? CMD_AREA1 : CMD_AREA0;
  assign busy    = (st != S_IDLE);

  assign abytes[0] = col_q[DW-1:0];
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_rowb
    assign abytes[g+1] = row_q[g*DW +: DW];
  end

  task automatic launch(input logic c, input logic a, input logic r, input logic [DW-1:0] b);
    cle    <= c;
    ale    <= a;
    rd     <= r;
    io_oe  <= !r;
    io_out <= b;
    go     <= 1'b1;
    issued <= 1'b1;
  endtask

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  issued <= 1'b0;  vph <= 1'b0;  spoll_q <= 1'b0;  vrf_q <= 1'b0;
      aidx <= '0;  col_q <= '0;  len_q <= '0;  left <= '0;  row_q <= '0;  wcnt <= '0;
      rb_s <= 2'b11;  din_take <= 1'b0;  done <= 1'b0;  prog_fail <= 1'b0;
      verify_fail <= 1'b0;  ce_n <= 1'b1;  cle <= 1'b0;  ale <= 1'b0;
      io_out <= '0;  io_oe <= 1'b0;  go <= 1'b0;  rd <= 1'b0;
    end else begin
      rb_s     <= {rb_s[0], rb};
      go       <= 1'b0;
      done     <= 1'b0;
      din_take <= 1'b0;
      if (ack) begin
        cle <= 1'b0;  ale <= 1'b0;  io_oe <= 1'b0;  issued <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          row_q <= row_addr;  col_q <= col_start;  len_q <= req_len;
          spoll_q <= status_poll;  vrf_q <= verify_en;  vph <= 1'b0;
          prog_fail <= 1'b0;  verify_fail <= 1'b0;  ce_n <= 1'b0;
          st <= S_PTR;
        end
        S_PTR:
          if (!issued) launch(1'b1, 1'b0, 1'b0, ptr_cmd);
          else if (ack) st <= vph ? S_ADR : S_SETUP;
        S_SETUP:
          if (!issued) launch(1'b1, 1'b0, 1'b0, CMD_LOAD);
          else if (ack) st <= S_ADR;
        S_ADR:
          if (!issued) launch(1'b0, 1'b1, 1'b0, abytes[aidx]);
          else if (ack) begin
            if (aidx == AIW'(ROW_BYTES)) begin
              aidx <= '0;
              left <= len_q;
              if (vph) begin
                wcnt <= CW'(RWAIT);
                st   <= S_RWAIT;
              end else st <= (len_q == '0) ? S_CONF : S_DATA;
            end else aidx <= aidx + 1'b1;
          end
        S_DATA:
          if (!issued) begin
            launch(1'b0, 1'b0, 1'b0, din);
            din_take <= 1'b1;
          end else if (ack) begin
            left <= left - 1'b1;
            if (left == COL_W'(1)) st <= S_CONF;
          end
        S_CONF:
          if (!issued) launch(1'b1, 1'b0, 1'b0, CMD_COMMIT);
          else if (ack) begin
            wcnt <= CW'(T_WB);
            st   <= S_WB;
          end
        S_WB:
          if (wcnt == '0) st <= spoll_q ? S_STCMD : S_RBW;
          else wcnt <= wcnt - 1'b1;
        S_RBW:
          if (rb_s[1]) st <= S_STCMD;
        S_STCMD:
          if (!issued) launch(1'b1, 1'b0, 1'b0, CMD_STATUS);
          else if (ack) begin
            wcnt <= CW'(T_WHR);
            st   <= S_WHR;
          end
        S_WHR:
          if (wcnt == '0) st <= S_STRD;
          else wcnt <= wcnt - 1'b1;
        S_STRD:
          if (!issued) launch(1'b0, 1'b0, 1'b1, '0);
          else if (ack && !(spoll_q && !rdata[6])) begin
            prog_fail <= rdata[0];
            if (rdata[0] || !vrf_q || len_q == '0) st <= S_FIN;
            else begin
              vph <= 1'b1;
              st  <= S_PTR;
            end
          end
        S_RWAIT:
          if (wcnt == '0) st <= S_RRBW;
          else wcnt <= wcnt - 1'b1;
        S_RRBW:
          if (rb_s[1]) st <= S_VRD;
        S_VRD:
          if (!issued) launch(1'b0, 1'b0, 1'b1, '0);
          else if (ack) begin
            if (rdata != din) verify_fail <= 1'b1;
            din_take <= 1'b1;
            left     <= left - 1'b1;
            if (left == COL_W'(1)) st <= S_FIN;
          end
        S_FIN: begin
          ce_n <= 1'b1;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(row_q) && $stable(col_q) && $stable(len_q)));

  // R7
  fail_skips_verify_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_STRD && ack && rdata[0] && (rdata[6] || !spoll_q)) |=> (st == S_FIN));

  // R11
  take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    din_take |=> !din_take);
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq #(
  parameter int  DW         = 8,
  parameter int  ROW_BYTES  = 2,
  parameter int  MAIN_BYTES = 512,
  parameter int  SPARE_BYTES = 16,
  parameter int  T_WLO      = 3,
  parameter int  T_WHI      = 2,
  parameter int  T_WB       = 10,
  parameter int  T_WHR      = 6,
  parameter int  T_RD       = 12,
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES + 1),
  localparam int ROW_W      = ROW_BYTES * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_start,
  input  logic [COL_W-1:0] byte_count,
  input  logic             status_poll,
  input  logic             verify_en,
  input  logic [DW-1:0]    din,
  output logic             din_take,
  output logic             busy,
  output logic             done,
  output logic             prog_fail,
  output logic             verify_fail,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [DW-1:0]    nand_io_out,
  output logic             nand_io_oe,
  input  logic [DW-1:0]    nand_io_in,
  input  logic             nand_rb
);
  logic          go, rd, ack;
  logic [DW-1:0] rdata;

  nps_ctrl #(
    .DW(DW), .ROW_BYTES(ROW_BYTES), .MAIN_BYTES(MAIN_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .COL_W(COL_W), .T_WB(T_WB), .T_WHR(T_WHR), .T_RD(T_RD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .row_addr(row_addr), .col_start(col_start),
    .byte_count(byte_count), .status_poll(status_poll), .verify_en(verify_en),
    .din(din), .din_take(din_take), .busy(busy), .done(done), .prog_fail(prog_fail),
    .verify_fail(verify_fail), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .go(go), .rd(rd), .ack(ack),
    .rdata(rdata), .rb(nand_rb)
  );

  nps_strobe #(.DW(DW), .T_LO(T_WLO), .T_HI(T_WHI)) u_strobe (
    .clk(clk), .rst(rst), .go(go), .rd(rd), .io_in(nand_io_in),
    .we_n(nand_we_n), .re_n(nand_re_n), .rdata(rdata), .ack(ack)
  );

  // R4
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |->
      ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));
endmodule

// File: tb/tb_nand_pgm_seq.sv
module tb_nand_pgm_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] row_addr = '0;
  logic [9:0]  col_start = '0, byte_count = '0;
  logic        status_poll = 1'b0, verify_en = 1'b0;
  logic [7:0]  din = '0;
  logic        din_take, busy, done, prog_fail, verify_fail;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        m_rb = 1'b1;

  always #5 clk = ~clk;

  nand_pgm_seq dut (
    .clk(clk), .rst(rst), .start(start), .row_addr(row_addr), .col_start(col_start),
    .byte_count(byte_count), .status_poll(status_poll), .verify_en(verify_en),
    .din(din), .din_take(din_take), .busy(busy), .done(done), .prog_fail(prog_fail),
    .verify_fail(verify_fail), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb(m_rb)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] pg [0:527];
  int   mptr = 0, rptr = 0, area = 0, ac = 0, busy_len = 0;
  bit   prog_on = 0, stat_mode = 0, m_fail = 0, m_corrupt = 0, rd_first = 0;
  event bz;

  always @(posedge nand_we_n) if (!rst && !nand_ce_n) begin
    if (nand_cle) begin
      case (nand_io_out)
        8'h00: begin area = 0; stat_mode = 0; prog_on = 0; ac = 0; end
        8'h01: begin area = 1; stat_mode = 0; prog_on = 0; ac = 0; end
        8'h50: begin area = 2; stat_mode = 0; prog_on = 0; ac = 0; end
        8'h80: begin prog_on = 1; stat_mode = 0; ac = 0; end
        8'h10: begin prog_on = 0; busy_len = 40; -> bz; end
        8'h70: stat_mode = 1;
        default: ;
      endcase
    end else if (nand_ale) begin
      if (ac == 0) mptr = (area == 2) ? 512 + int'(nand_io_out[3:0]) : area * 256 + int'(nand_io_out);
      ac++;
      if (ac == 3 && !prog_on) begin
        rptr = mptr; rd_first = 1; busy_len = 20; -> bz;
      end
    end else if (prog_on && mptr < 528) begin
      pg[mptr] = nand_io_out;
      mptr++;
    end
  end

  always @(posedge nand_re_n) if (!stat_mode) begin rptr++; rd_first = 0; end

  always begin
    @(bz);
    repeat (4) @(posedge clk);
    m_rb = 1'b0;
    repeat (busy_len) @(posedge clk);
    m_rb = 1'b1;
  end

  assign nand_io_in = stat_mode ? {1'b1, m_rb, 5'b0, m_fail}
                    : (((rptr < 528) ? pg[rptr] : 8'hFF) ^ ((m_corrupt && rd_first) ? 8'h01 : 8'h00));

  // ---------------- scoreboard ----------------
  logic [9:0] exp_q[$];
  bit   cur_spoll = 0, chk70 = 0;
  time  t_fall = 0, t_prev_fall = 0, t70 = 0;
  logic [9:0] at_fall;

  always @(negedge nand_we_n) if (!rst) begin
    if (t_prev_fall != 0)
      check($time - t_prev_fall >= 50, "R4 write cycle ns", int'($time - t_prev_fall), 50);
    t_prev_fall = $time;
    t_fall = $time;
    at_fall = {nand_cle, nand_ale, nand_io_out};
    check(nand_re_n, "R4 strobes overlap", int'(nand_re_n), 1);
  end

  always @(posedge nand_we_n) if (!rst) begin
    logic [9:0] e;
    check($time - t_fall >= 25, "R4 write low ns", int'($time - t_fall), 25);
    check({nand_cle, nand_ale, nand_io_out} == at_fall, "R4 bus stable",
          int'({nand_cle, nand_ale, nand_io_out}), int'(at_fall));
    if (exp_q.size() == 0) check(0, "R2 unexpected write", int'({nand_cle, nand_ale, nand_io_out}), 0);
    else begin
      e = exp_q.pop_front();
      check({nand_cle, nand_ale, nand_io_out} == e, "R2 bus order",
            int'({nand_cle, nand_ale, nand_io_out}), int'(e));
    end
    if (nand_cle && nand_io_out == 8'h70) begin
      t70 = $time; chk70 = 1;
      if (!cur_spoll) check(m_rb == 1'b1, "R5 status before ready", int'(m_rb), 1);
    end
  end

  int n_stat_reads = 0;
  always @(negedge nand_re_n) if (!rst) begin
    if (chk70) begin
      check($time - t70 >= 60, "R6 WE-to-RE ns", int'($time - t70), 60);
      chk70 = 0;
    end
    if (stat_mode) n_stat_reads++;
  end

  // ---------------- data stream driver ----------------
  int   idx = 0, cur_len = 0, take_cnt = 0, done_cnt = 0;
  logic [7:0] seed = 0;

  always @(negedge clk) begin
    if (din_take) begin
      take_cnt++;
      idx = (idx + 1 >= cur_len) ? 0 : idx + 1;
    end
    din = seed + 8'(idx * 3);
  end

  always @(posedge clk) if (!rst && done) done_cnt++;

  function automatic logic [7:0] ptr_of(input int col);
    return (col >= 512) ? 8'h50 : (col >= 256) ? 8'h01 : 8'h00;
  endfunction

  task automatic run(input logic [15:0] row, input int col, input int cnt, input bit vrf,
                     input bit spoll, input bit finj, input bit vinj, input bit second_start,
                     input string name);
    int len, room, takes_exp, d0;
    bit got;
    room = (col >= 528) ? 0 : 528 - col;
    len  = (cnt < room) ? cnt : room;
    for (int i = 0; i < 528; i++) pg[i] = 8'hFF;
    m_fail = finj; m_corrupt = vinj; cur_spoll = spoll; n_stat_reads = 0;
    seed = row[7:0]; idx = 0; cur_len = len; take_cnt = 0;
    exp_q.push_back({2'b10, ptr_of(col)});
    exp_q.push_back({2'b10, 8'h80});
    exp_q.push_back({2'b01, 8'(col)});
    exp_q.push_back({2'b01, row[7:0]});
    exp_q.push_back({2'b01, row[15:8]});
    for (int i = 0; i < len; i++) exp_q.push_back({2'b00, row[7:0] + 8'(i * 3)});
    exp_q.push_back({2'b10, 8'h10});
    exp_q.push_back({2'b10, 8'h70});
    if (vrf && !finj && len > 0) begin
      exp_q.push_back({2'b10, ptr_of(col)});
      exp_q.push_back({2'b01, 8'(col)});
      exp_q.push_back({2'b01, row[7:0]});
      exp_q.push_back({2'b01, row[15:8]});
    end
    takes_exp = len * ((vrf && !finj && len > 0) ? 2 : 1);
    d0 = done_cnt;
    @(negedge clk);
    row_addr = row; col_start = 10'(col); byte_count = 10'(cnt);
    verify_en = vrf; status_poll = spoll; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {"R9 busy after start ", name}, int'(busy), 1);
    if (second_start) begin
      repeat (30) @(negedge clk);
      row_addr = 16'hFFFF; col_start = 10'd600; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 0;
    for (int c = 0; c < 5000 && !got; c++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    check(got, {"R9 done seen ", name}, int'(got), 1);
    check(busy == 1'b0 && nand_ce_n == 1'b1, {"R9 idle at done ", name},
          int'({busy, nand_ce_n}), 1);
    check(prog_fail == finj, {"R7 prog_fail ", name}, int'(prog_fail), int'(finj));
    check(verify_fail == (vrf && !finj && vinj && len > 0), {"R8 verify_fail ", name},
          int'(verify_fail), int'(vrf && !finj && vinj && len > 0));
    @(negedge clk);
    check(done == 1'b0, {"R9 done single cycle ", name}, int'(done), 0);
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, {"R3 all expected writes seen ", name}, exp_q.size(), 0);
    exp_q.delete();
    check(take_cnt == takes_exp, {"R11 take count ", name}, take_cnt, takes_exp);
    check(done_cnt - d0 == 1, {"R10 one done per op ", name}, done_cnt - d0, 1);
    check(busy == 1'b0, {"R10 stays idle ", name}, int'(busy), 0);
    if (spoll) check(n_stat_reads >= 2, {"R6 repeated status reads ", name}, n_stat_reads, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes high in reset",
          int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    check(!nand_cle && !nand_ale && !nand_io_oe, "R1 latches low in reset",
          int'({nand_cle, nand_ale, nand_io_oe}), 0);
    check(!busy && !done && !prog_fail && !verify_fail && !din_take, "R1 status low in reset",
          int'({busy, done, prog_fail, verify_fail, din_take}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    run(16'h1234,   0,  4, 1, 0, 0, 0, 0, "area0 verify");
    run(16'hA55A, 300,  3, 0, 1, 0, 0, 0, "area1 status poll");
    run(16'h0007, 520, 20, 1, 0, 0, 0, 0, "spare clamp");
    run(16'h00FF,  10,  5, 1, 1, 1, 0, 0, "program error");
    run(16'h0100, 100,  6, 1, 0, 0, 1, 0, "verify mismatch");
    run(16'h0042,   0,  0, 1, 0, 0, 0, 0, "zero length");
    run(16'h3333, 256,  2, 0, 0, 0, 0, 1, "second start ignored");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule